// File: doc/BRIEF.md
# Display Blanking and Brightness Stage

This stage sits at the end of a pixel pipeline, just before the video output. A single write-only control register holds a blanking bit and a four-bit brightness level. Every incoming 15-bit pixel, with 5 bits per colour, is either scaled by the brightness level or replaced by black. The result is registered. Horizontal and vertical sync travel alongside the pixel with the same one-cycle delay, so the display keeps a stable raster even when the picture is black.

The stage also tells the memory arbiter when video, object and palette memories may be touched. Access is allowed at all times while blanking is on, and otherwise only inside vertical blank. The first vertical blank line is selected by an overscan input.

One side effect is implemented. A register write that lands on the first vertical blank line while blanking is already on emits a one-cycle object-address-reset pulse for the sprite logic.

Top module: `display_blank_stage`

## Requirements
- R1: After reset, blanking is on and brightness is 0. The pixel output is 0 and the reset pulse is low.
- R2: While control bit 7 (blanking) is 1, the pixel output is 0 whatever the incoming pixel and brightness are.
- R3: With blanking off and brightness N taken from control bits 3..0, each channel c of the pixel is output as (c*(N+1))>>4 when N is 1..15, and as 0 when N is 0. The channels are pixel bits 4..0, 9..5 and 14..10.
- R4: The pixel output is the input pixel from one clock earlier, processed with the register value in force in that cycle. A register write takes effect on the cycle after its strobe.
- R5: Control bits 6..4 are ignored. Writes that differ only in those bits give identical output.
- R6: Both sync outputs equal their inputs delayed by one clock, with blanking on or off.
- R7: The memory-access flag is 1 exactly when blanking is on or the line number is at or past the first vertical blank line. That line is 225, or 240 when the overscan input is 1.
- R8: A write strobe on the first vertical blank line, while blanking is already on before that write, raises the reset pulse for exactly the following cycle. No other write raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| line_num | input | 9 | Current scanline number |
| overscan | input | 1 | 1 selects 240 as the first vertical blank line, 0 selects 225 |
| pix_in | input | 15 | Incoming pixel, 5 bits per colour |
| hsync_in | input | 1 | Horizontal sync in |
| vsync_in | input | 1 | Vertical sync in |
| pix_out | output | 15 | Scaled or blanked pixel |
| hsync_out | output | 1 | Horizontal sync, one cycle delayed |
| vsync_out | output | 1 | Vertical sync, one cycle delayed |
| mem_ok | output | 1 | Video, object and palette memory may be accessed |
| oam_rst_pulse | output | 1 | One-cycle object address reset pulse |

## Verification
The embedded assertions check the following on every cycle:
- each sync output equals its input from the previous clock;
- a write that sets blanking opens memory access on the next cycle;
- a brightness-zero write with blanking off yields a black pixel;
- each reset pulse follows a write strobe.

Only the bench scenarios can show the exact per-channel scaling for every brightness level. They also show that the ignored bits have no effect and that the first vertical blank line moves with overscan. Finally, they show that a write on that line raises the pulse only when blanking was already on.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int CHAN_W  = 5;
    localparam int BRT_W   = 4;
    localparam int LINE_W  = 9;
    localparam int PIX_W   = 3 * CHAN_W;

    typedef struct packed {
        logic [CHAN_W-1:0] c2;
        logic [CHAN_W-1:0] c1;
        logic [CHAN_W-1:0] c0;
    } pixel_t;

    typedef struct packed {
        logic             blank;
        logic [BRT_W-1:0] level;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{blank: 1'b1, level: '0};

    function automatic logic [CHAN_W-1:0] scale_chan(
        input logic [CHAN_W-1:0] c,
        input logic [BRT_W-1:0]  n
    );
        logic [CHAN_W+BRT_W:0] prod;
        prod = {{(BRT_W+1){1'b0}}, c} * ({{(CHAN_W+1){1'b0}}, n} + 1'b1);
        if (n == '0) return '0;
        return prod[CHAN_W+BRT_W-1:BRT_W];
    endfunction
endpackage

// File: rtl/dbs_ctrl_reg.sv
module dbs_ctrl_reg
    import dbs_pkg::*;
#(
    parameter int VBL_NORMAL   = 225,
    parameter int VBL_OVERSCAN = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [LINE_W-1:0] line_num,
    input  logic              overscan,
    output ctrl_t             ctrl,
    output logic              mem_ok,
    output logic              oam_rst_pulse
);
    localparam logic [LINE_W-1:0] FIRST_N = LINE_W'(VBL_NORMAL);
    localparam logic [LINE_W-1:0] FIRST_O = LINE_W'(VBL_OVERSCAN);

    logic [LINE_W-1:0] first_vbl;
    logic              on_first;

    always_comb begin
        first_vbl = overscan ? FIRST_O : FIRST_N;
        on_first  = (line_num == first_vbl);
        mem_ok    = ctrl.blank || (line_num >= first_vbl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl          <= CTRL_RESET;
            oam_rst_pulse <= 1'b0;
        end else begin
            oam_rst_pulse <= wr_en && ctrl.blank && on_first;
            if (wr_en) begin
                ctrl.blank <= wr_data[7];
                ctrl.level <= wr_data[BRT_W-1:0];
            end
        end
    end

    AST_BLANK_OPENS_MEM: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[7]) |=> mem_ok); // R7
    AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(oam_rst_pulse) |-> $past(wr_en)); // R8
endmodule

// File: rtl/dbs_pixel_path.sv
module dbs_pixel_path
    import dbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctrl_t  ctrl,
    input  pixel_t pix_in,
    input  logic   hsync_in,
    input  logic   vsync_in,
    output pixel_t pix_out,
    output logic   hsync_out,
    output logic   vsync_out
);
    pixel_t scaled;

    always_comb begin
        scaled.c0 = scale_chan(pix_in.c0, ctrl.level);
        scaled.c1 = scale_chan(pix_in.c1, ctrl.level);
        scaled.c2 = scale_chan(pix_in.c2, ctrl.level);
    end

    always_ff @(posedge clk) begin
        if (rst) pix_out <= '0;
        else     pix_out <= ctrl.blank ? pixel_t'('0) : scaled;
    end

    always_ff @(posedge clk) begin
        hsync_out <= hsync_in;
        vsync_out <= vsync_in;
    end

    AST_SYNC_H_DELAY: assert property (@(posedge clk) disable iff (rst)
        hsync_out == $past(hsync_in)); // R6
    AST_SYNC_V_DELAY: assert property (@(posedge clk) disable iff (rst)
        vsync_out == $past(vsync_in)); // R6
    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl.blank) |-> (pix_out == '0)); // R2
endmodule

// File: rtl/display_blank_stage.sv
module display_blank_stage
    import dbs_pkg::*;
#(
    parameter int VBL_NORMAL   = 225,
    parameter int VBL_OVERSCAN = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [LINE_W-1:0] line_num,
    input  logic              overscan,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              hsync_in,
    input  logic              vsync_in,
    output logic [PIX_W-1:0]  pix_out,
    output logic              hsync_out,
    output logic              vsync_out,
    output logic              mem_ok,
    output logic              oam_rst_pulse
);
    ctrl_t  ctrl;
    pixel_t pix_q;

    dbs_ctrl_reg #(
        .VBL_NORMAL  (VBL_NORMAL),
        .VBL_OVERSCAN(VBL_OVERSCAN)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .line_num     (line_num),
        .overscan     (overscan),
        .ctrl         (ctrl),
        .mem_ok       (mem_ok),
        .oam_rst_pulse(oam_rst_pulse)
    );

    dbs_pixel_path u_path (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .pix_in   (pixel_t'(pix_in)),
        .hsync_in (hsync_in),
        .vsync_in (vsync_in),
        .pix_out  (pix_q),
        .hsync_out(hsync_out),
        .vsync_out(vsync_out)
    );

    assign pix_out = pix_q;

    AST_ZERO_LEVEL_BLACK: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en, 2) && !$past(wr_data[7], 2) && ($past(wr_data[3:0], 2) == 4'd0)
         && !$past(wr_en)) |-> (pix_out == '0)); // R3
endmodule

// File: tb/display_blank_stage_bench.sv
module display_blank_stage_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [8:0]  line_num = 9'd0;
    logic        overscan = 1'b0;
    logic [14:0] pix_in = 15'h0;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic [14:0] pix_out;
    logic        hsync_out, vsync_out, mem_ok, oam_rst_pulse;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    display_blank_stage u_display_blank_stage (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .line_num(line_num), .overscan(overscan), .pix_in(pix_in),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .pix_out(pix_out),
        .hsync_out(hsync_out), .vsync_out(vsync_out), .mem_ok(mem_ok),
        .oam_rst_pulse(oam_rst_pulse)
    );

    // behavioural reference
    bit          m_blank;
    int          m_level;
    logic [14:0] e_pix;
    logic        e_h, e_v, e_pulse;
    int          pulse_count = 0;

    function automatic logic [14:0] ref_pixel(input logic [14:0] p, input bit blank, input int n);
        logic [14:0] r = '0;
        if (blank || n == 0) return 15'h0;
        for (int ch = 0; ch < 3; ch++) begin
            int c = int'(p[ch*5 +: 5]);
            r[ch*5 +: 5] = 5'((c * (n + 1)) / 16);
        end
        return r;
    endfunction

    always @(posedge clk) begin
        e_h = hsync_in;
        e_v = vsync_in;
        if (rst) begin
            m_blank = 1; m_level = 0; e_pix = '0; e_pulse = 0;
        end else begin
            e_pix   = ref_pixel(pix_in, m_blank, m_level);
            e_pulse = wr_en && m_blank && (line_num == (overscan ? 9'd240 : 9'd225));
            if (wr_en) begin
                m_blank = wr_data[7];
                m_level = int'(wr_data[3:0]);
            end
        end
    end

    task automatic compare();
        bit e_mem;
        e_mem = m_blank || (line_num >= (overscan ? 9'd240 : 9'd225));
        vectors++;
        if (pix_out !== e_pix) begin
            fails++;
            $display("FAIL R2/R3/R4/R5 pixel: got %h expected %h", pix_out, e_pix);
        end
        if (hsync_out !== e_h || vsync_out !== e_v) begin
            fails++;
            $display("FAIL R6 sync: got %b%b expected %b%b", hsync_out, vsync_out, e_h, e_v);
        end
        if (mem_ok !== e_mem) begin
            fails++;
            $display("FAIL R7 mem_ok: got %b expected %b", mem_ok, e_mem);
        end
        if (oam_rst_pulse !== e_pulse) begin
            fails++;
            $display("FAIL R8 pulse: got %b expected %b", oam_rst_pulse, e_pulse);
        end
        if (oam_rst_pulse) pulse_count++;
    endtask

    int seed = 12345;
    task automatic step(input bit we, input logic [7:0] d, input int ln, input bit os);
        @(negedge clk);
        if (!rst) compare();
        seed = seed * 1103515245 + 12345;
        wr_en    = we;
        wr_data  = d;
        line_num = 9'(ln);
        overscan = os;
        pix_in   = 15'(seed >>> 8);
        hsync_in = seed[3];
        vsync_in = seed[9];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step(0, 8'h00, 10, 0);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        vectors++;
        if (pix_out !== 15'h0 || oam_rst_pulse !== 1'b0 || mem_ok !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset: got pix %h pulse %b mem %b expected 0000 0 1",
                     pix_out, oam_rst_pulse, mem_ok);
        end
        repeat (5) step(0, 8'h00, 20, 0);
        // R3 R4: every brightness level, blanking off
        for (int n = 0; n < 16; n++) begin
            step(1, 8'(n), 30, 0);
            repeat (6) step(0, 8'h00, 30 + n, 0);
        end
        // R5: ignored bits set
        step(1, 8'h7A, 40, 0);
        repeat (6) step(0, 8'h00, 41, 0);
        step(1, 8'h0A, 42, 0);
        repeat (6) step(0, 8'h00, 43, 0);
        // R2 R6: blanking with full brightness
        step(1, 8'h8F, 50, 0);
        repeat (10) step(0, 8'h00, 51, 0);
        // R7: line sweep around both boundaries, blanking off
        step(1, 8'h0F, 100, 0);
        for (int ln = 222; ln < 244; ln++) begin
            step(0, 8'h00, ln, 0);
            step(0, 8'h00, ln, 1);
        end
        // R8: write on first vblank line with blanking off -> no pulse
        step(1, 8'h85, 225, 0);
        repeat (3) step(0, 8'h00, 225, 0);
        // blanking now on: write on 225 -> pulse
        step(1, 8'h85, 225, 0);
        repeat (3) step(0, 8'h00, 225, 0);
        // overscan: 225 is not first line, 240 is
        step(1, 8'h85, 225, 1);
        repeat (3) step(0, 8'h00, 225, 1);
        step(1, 8'h03, 240, 1);
        repeat (3) step(0, 8'h00, 240, 1);
        // blank off now: write on 240 overscan -> no pulse
        step(1, 8'h83, 240, 1);
        repeat (3) step(0, 8'h00, 100, 0);
        // wrong line with blank on
        step(1, 8'h83, 226, 0);
        repeat (3) step(0, 8'h00, 100, 0);
        step(0, 8'h00, 100, 0);
        // R8: exactly two pulses expected in this sequence
        vectors++;
        if (pulse_count != 2) begin
            fails++;
            $display("FAIL R8 pulse count: got %0d expected 2", pulse_count);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule